// File: doc/BRIEF.md
# Coprocessor Status Word Register

This block holds the 16-bit status word of a floating-point coprocessor. It keeps a 3-bit stack-top pointer, four condition code bits, a stack fault flag and six sticky exception flags. The datapath sets exception flags with single-cycle pulses. It can also write the condition codes and the stack-top pointer, and it can report a stack fault together with its direction.

The word carries two derived bits: an error summary and a busy mirror. The block never stores either of them. Both are recomputed every cycle from the sticky flags and an external 6-bit mask, so a mask change reaches them in the same cycle. The error summary also drives an active-low error pin.

Four commands act on the whole word: initialize, clear exceptions, save, and whole-word load. A save lets the current word be read during its cycle and then clears the exception state. A whole-word load replaces the stored fields from a 16-bit value. The derived bits of that value are discarded and recomputed from the new flags and the current masks.

Top module: `fpu_status_word`

## Requirements
- R1: While `rstN` is low (asynchronous), `statusWord` reads 0x0000 and `errorN` is 1.
- R2: `statusWord` layout: bit 15 busy mirror, bit 14 C3, bits 13:11 stack-top pointer, bits 10:8 C2,C1,C0, bit 7 error summary, bit 6 stack fault, bits 5:0 exception flags. On `ccWrData`, bit 3 is C3, bit 2 is C2, bit 1 is C1 and bit 0 is C0. A condition code write takes effect at the next clock edge.
- R3: Bit 7 is 1 exactly when some exception flag is 1 while its `excMask` bit is 0. A mask change updates it in the same cycle, with no clock edge needed.
- R4: Bit 15 always equals bit 7.
- R5: `errorN` is 0 exactly when bit 7 is 1.
- R6: A 1 on `excPulse[i]` sets exception flag i at the next edge. A set flag stays set through cycles without pulses and through condition code or pointer writes.
- R7: `cmdClear` zeroes the six exception flags and the stack fault bit at the next edge. It wins over an `excPulse` or `faultSet` in the same cycle.
- R8: During a `cmdSave` cycle the read port shows the word as it was before the save. After the edge, the exception flags and the stack fault bit are 0, while the condition codes and pointer are kept.
- R9: `cmdLoad` copies `loadWord` bits 14:8, 6 and 5:0 into their fields at the next edge. Loaded bits 15 and 7 are ignored, and both are recomputed from the loaded flags and the current mask. A load overrides pulses and writes in the same cycle.
- R10: `cmdInit` zeroes all stored fields in one clock, overriding every other input in that cycle.
- R11: `topWrEn` writes `topWrData` into bits 13:11 at the next edge. Value k names data register k.
- R12: `faultSet` sets the stack fault bit and writes C1 = `faultOvf` (1 overflow, 0 underflow). This takes priority over a condition code write to C1 in the same cycle. The stack fault bit is sticky like the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excPulse | input | 6 | Exception-set pulses, one per flag |
| faultSet | input | 1 | Stack fault report |
| faultOvf | input | 1 | Fault direction: 1 overflow, 0 underflow |
| ccWrEn | input | 1 | Condition code write enable |
| ccWrData | input | 4 | New condition codes {C3,C2,C1,C0} |
| topWrEn | input | 1 | Stack-top pointer write enable |
| topWrData | input | 3 | New stack-top pointer |
| cmdInit | input | 1 | Initialize command |
| cmdClear | input | 1 | Clear-exceptions command |
| cmdSave | input | 1 | Save command |
| cmdLoad | input | 1 | Whole-word load command |
| loadWord | input | 16 | Word supplied with a load |
| excMask | input | 6 | Exception masks, 1 = masked |
| statusWord | output | 16 | Read port |
| errorN | output | 1 | Active-low error output |

## Verification
The bench goes after command priority: a clear racing an exception pulse, a load racing pulses and writes, and an initialize racing a load. A design with the order wrong would leave a flag set or keep a stale field. It loads words whose bits 15 and 7 disagree with their flags. A design that stored those bits would show an error with every flag masked, or miss one that is unmasked. It changes the mask between clock edges, which catches a summary that has been registered. It also reads the word inside a save cycle, which catches a save that clears before the read.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
  localparam int NUM_EXC = 6;
  localparam int TOP_W   = 3;
  localparam int CC_W    = 4;
  localparam int WORD_W  = 2 + TOP_W + CC_W + 1 + NUM_EXC;
  // bit positions inside the word
  localparam int BUSY_BIT  = WORD_W - 1;
  localparam int C3_BIT    = WORD_W - 2;
  localparam int TOP_LSB   = C3_BIT - TOP_W;
  localparam int CCLO_LSB  = TOP_LSB - (CC_W - 1);
  localparam int SUM_BIT   = NUM_EXC + 1;
  localparam int FAULT_BIT = NUM_EXC;

  typedef struct packed {
    logic clrAll;
    logic loadAll;
    logic clrExc;
    logic setExc;
    logic wrCc;
    logic wrTop;
    logic setFault;
  } swStrobe_t;
endpackage

// File: rtl/fpsw_ctrl.sv
module fpsw_ctrl
  import fpsw_pkg::*;
(
  input  logic      cmdInit,
  input  logic      cmdLoad,
  input  logic      cmdClear,
  input  logic      cmdSave,
  input  logic      ccWrEn,
  input  logic      topWrEn,
  input  logic      faultSet,
  output swStrobe_t strb
);
  logic higher;
  logic clearing;

  always_comb begin
    higher        = cmdInit || cmdLoad;
    clearing      = cmdClear || cmdSave;
    strb.clrAll   = cmdInit;
    strb.loadAll  = !cmdInit && cmdLoad;
    strb.clrExc   = !higher && clearing;
    strb.setExc   = !higher && !clearing;
    strb.setFault = !higher && !clearing && faultSet;
    strb.wrCc     = !higher && ccWrEn;
    strb.wrTop    = !higher && topWrEn;
  end
endmodule

// File: rtl/fpsw_datapath.sv
module fpsw_datapath
  import fpsw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  swStrobe_t          strb,
  input  logic [NUM_EXC-1:0] excPulse,
  input  logic               faultOvf,
  input  logic [CC_W-1:0]    ccWrData,
  input  logic [TOP_W-1:0]   topWrData,
  input  logic [NUM_EXC-1:0] excMask,
  input  logic [WORD_W-1:0]  loadWord,
  output logic [WORD_W-1:0]  statusWord,
  output logic               errorN
);
  logic [NUM_EXC-1:0] excFlags;
  logic               stackFault;
  logic [CC_W-1:0]    ccReg;
  logic [TOP_W-1:0]   topPtr;
  logic               summary;

  for (genvar g = 0; g < NUM_EXC; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          excFlags[g] <= 1'b0;
      else if (strb.clrAll || strb.clrExc) excFlags[g] <= 1'b0;
      else if (strb.loadAll)              excFlags[g] <= loadWord[g];
      else if (strb.setExc && excPulse[g]) excFlags[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackFault <= 1'b0;
      ccReg      <= '0;
      topPtr     <= '0;
    end else if (strb.clrAll) begin
      stackFault <= 1'b0;
      ccReg      <= '0;
      topPtr     <= '0;
    end else if (strb.loadAll) begin
      stackFault <= loadWord[FAULT_BIT];
      ccReg      <= {loadWord[C3_BIT], loadWord[CCLO_LSB +: CC_W-1]};
      topPtr     <= loadWord[TOP_LSB +: TOP_W];
    end else begin
      if (strb.clrExc)   stackFault <= 1'b0;
      if (strb.setFault) stackFault <= 1'b1;
      if (strb.wrCc)     ccReg <= ccWrData;
      if (strb.setFault) ccReg[1] <= faultOvf;
      if (strb.wrTop)    topPtr <= topWrData;
    end
  end

  always_comb begin
    summary    = |(excFlags & ~excMask);
    statusWord = {summary, ccReg[CC_W-1], topPtr, ccReg[CC_W-2:0],
                  summary, stackFault, excFlags};
    errorN     = ~summary;
  end

  // R6: without clear, init or load, no flag ever drops
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrAll && !strb.clrExc && !strb.loadAll)
      |=> ((excFlags & $past(excFlags)) == $past(excFlags)));
  // R7: clear empties flags and fault even with pulses present
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrExc |=> (excFlags == '0 && !stackFault));
  // R9: load takes the flags from the supplied word
  a_r9_load_flags: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAll |=> (excFlags == $past(loadWord[NUM_EXC-1:0])));
  // R10: init leaves every stored field zero
  a_r10_init_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (excFlags == '0 && ccReg == '0 && topPtr == '0 && !stackFault));
  // R11: pointer write lands on the next edge
  a_r11_top_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTop |=> (topPtr == $past(topWrData)));
  // R12: a fault report records its direction in C1
  a_r12_fault_dir: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFault |=> (stackFault && ccReg[1] == $past(faultOvf)));
endmodule

// File: rtl/fpu_status_word.sv
module fpu_status_word
  import fpsw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  excPulse,
  input  logic        faultSet,
  input  logic        faultOvf,
  input  logic        ccWrEn,
  input  logic [3:0]  ccWrData,
  input  logic        topWrEn,
  input  logic [2:0]  topWrData,
  input  logic        cmdInit,
  input  logic        cmdClear,
  input  logic        cmdSave,
  input  logic        cmdLoad,
  input  logic [15:0] loadWord,
  input  logic [5:0]  excMask,
  output logic [15:0] statusWord,
  output logic        errorN
);
  swStrobe_t strb;

  fpsw_ctrl u_ctrl (
    .cmdInit  (cmdInit),
    .cmdLoad  (cmdLoad),
    .cmdClear (cmdClear),
    .cmdSave  (cmdSave),
    .ccWrEn   (ccWrEn),
    .topWrEn  (topWrEn),
    .faultSet (faultSet),
    .strb     (strb)
  );

  fpsw_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .excPulse   (excPulse),
    .faultOvf   (faultOvf),
    .ccWrData   (ccWrData),
    .topWrData  (topWrData),
    .excMask    (excMask),
    .loadWord   (loadWord),
    .statusWord (statusWord),
    .errorN     (errorN)
  );

  // R5: error pin low only when the read port shows a summary
  a_r5_pin_matches: assert property (@(posedge clk) disable iff (!rstN)
    (!errorN) |-> statusWord[7]);
endmodule

// File: tb/sim_fpu_status_word.sv
`timescale 1ns/100ps
module sim_fpu_status_word;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  excPulse = '0;
  logic        faultSet = 1'b0, faultOvf = 1'b0;
  logic        ccWrEn = 1'b0;
  logic [3:0]  ccWrData = '0;
  logic        topWrEn = 1'b0;
  logic [2:0]  topWrData = '0;
  logic        cmdInit = 1'b0, cmdClear = 1'b0, cmdSave = 1'b0, cmdLoad = 1'b0;
  logic [15:0] loadWord = '0;
  logic [5:0]  excMask = 6'h3F;
  logic [15:0] statusWord;
  logic        errorN;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  fpu_status_word u0 (.*);

  typedef struct packed {
    logic init, clr, save, load;
    logic [5:0] exc;
    logic ccEn; logic [3:0] cc;
    logic topEn; logic [2:0] top;
    logic flt, ovf;
    logic [5:0] mask;
    logic [15:0] ldw;
    logic [15:0] expW;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    //  in cl sv ld  exc       ccEn cc      tEn top     f    o    mask     ldw       expW
    '{1'b0,1'b0,1'b0,1'b0,6'h01,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h3F,16'h0000,16'h0001}, // R6
    '{1'b0,1'b0,1'b0,1'b0,6'h04,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h3F,16'h0000,16'h0005}, // R6
    '{1'b0,1'b0,1'b0,1'b0,6'h00,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h3E,16'h0000,16'h8085}, // R3 R4
    '{1'b0,1'b0,1'b0,1'b0,6'h00,1'b1,4'hA,1'b0,3'd0,1'b0,1'b0,6'h3E,16'h0000,16'hC285}, // R2
    '{1'b0,1'b0,1'b0,1'b0,6'h00,1'b0,4'h0,1'b1,3'd5,1'b0,1'b0,6'h3E,16'h0000,16'hEA85}, // R11
    '{1'b0,1'b1,1'b0,1'b0,6'h20,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h3E,16'h0000,16'h6A00}, // R7
    '{1'b0,1'b0,1'b0,1'b0,6'h00,1'b1,4'h0,1'b0,3'd0,1'b1,1'b1,6'h3F,16'h0000,16'h2A40}, // R12
    '{1'b0,1'b0,1'b0,1'b0,6'h01,1'b0,4'h0,1'b0,3'd0,1'b1,1'b0,6'h3F,16'h0000,16'h2841}, // R12
    '{1'b0,1'b0,1'b1,1'b0,6'h00,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h3F,16'h0000,16'h2800}, // R8
    '{1'b0,1'b0,1'b0,1'b1,6'h00,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h3F,16'hFFFF,16'h7F7F}, // R9
    '{1'b0,1'b0,1'b0,1'b1,6'h00,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h2F,16'h0010,16'h8090}, // R9
    '{1'b0,1'b0,1'b0,1'b1,6'h00,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h00,16'h8080,16'h0000}, // R9
    '{1'b0,1'b0,1'b0,1'b1,6'h01,1'b1,4'hF,1'b0,3'd0,1'b0,1'b0,6'h3F,16'h0800,16'h0800}, // R9
    '{1'b1,1'b0,1'b0,1'b1,6'h3F,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h00,16'hFFFF,16'h0000}, // R10
    '{1'b0,1'b0,1'b0,1'b0,6'h02,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h3D,16'h0000,16'h8082}, // R5
    '{1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h3D,16'h0000,16'h0000}, // R10
    '{1'b0,1'b0,1'b0,1'b0,6'h00,1'b1,4'h5,1'b1,3'd7,1'b0,1'b0,6'h3F,16'h0000,16'h3D00}, // R2 R11
    '{1'b0,1'b0,1'b0,1'b0,6'h20,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,6'h1F,16'h0000,16'hBDA0}  // R3 R5
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    excPulse = '0; faultSet = 1'b0; faultOvf = 1'b0; ccWrEn = 1'b0; topWrEn = 1'b0;
    cmdInit = 1'b0; cmdClear = 1'b0; cmdSave = 1'b0; cmdLoad = 1'b0;
  endtask

  initial begin
    #1;
    check("R1 reset word", statusWord, 16'h0000);
    check("R1 reset errorN", {15'd0, errorN}, 16'h0001);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      cmdInit = VEC[i].init; cmdClear = VEC[i].clr; cmdSave = VEC[i].save;
      cmdLoad = VEC[i].load; excPulse = VEC[i].exc; ccWrEn = VEC[i].ccEn;
      ccWrData = VEC[i].cc; topWrEn = VEC[i].topEn; topWrData = VEC[i].top;
      faultSet = VEC[i].flt; faultOvf = VEC[i].ovf; excMask = VEC[i].mask;
      loadWord = VEC[i].ldw;
      @(negedge clk);
      check($sformatf("R2-vector%0d word", i), statusWord, VEC[i].expW);
      check($sformatf("R5-vector%0d errorN", i), {15'd0, errorN}, {15'd0, ~VEC[i].expW[7]});
      idle();
    end
    // R8: the save cycle still shows the old word, clearing follows the edge
    cmdSave = 1'b1;
    #1;
    check("R8 read during save", statusWord, 16'hBDA0);
    @(negedge clk);
    check("R8 after save", statusWord, 16'h3D00);
    idle();
    // R6: flag set, then ignored writes keep it
    excPulse = 6'h01; excMask = 6'h3F;
    @(negedge clk);
    idle();
    topWrEn = 1'b1; topWrData = 3'd7; ccWrEn = 1'b1; ccWrData = 4'h5;
    @(negedge clk);
    idle();
    check("R6 flag kept", statusWord, 16'h3D01);
    // R3: mask change acts without a clock edge
    excMask = 6'h3E;
    #1;
    check("R3 same-cycle summary", statusWord, 16'hBD81);
    check("R5 same-cycle errorN", {15'd0, errorN}, 16'h0000);
    @(negedge clk);
    // R1: asynchronous reset mid-run
    rstN = 1'b0;
    #1;
    check("R1 async reset word", statusWord, 16'h0000);
    check("R1 async reset errorN", {15'd0, errorN}, 16'h0001);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule